// File: doc/BRIEF.md
# Cascadable Bidirectional Line Capture

This block is the digital intake of a display column driver. On every clock it accepts six 8-bit colour bytes (two RGB pixels) and writes them into a 384-byte line store. A capture begins when a start pulse arrives on whichever of the two cascade pins is the input for the current direction. It runs for exactly 64 data clocks and then stops by itself. At that point it sends a one-clock start pulse out of the other cascade pin, so several devices can be chained and each one fills its own part of a wide line.

A direction input sets two things: the order in which the 64 byte groups fill the store, and which cascade pin listens and which one drives. Each half of the byte lanes has its own inversion control. When a control is high, the bytes in that half are stored complemented; this lets the sender reduce switching on the bus. The later stage that moves the line to the outputs reads the store through a combinational byte read port.

Top module: `lcap_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `line_done` are 0 and both cascade outputs are 0.
- R2: With `shift_right`=1, cascade pin A is the input (`casc_a_oe`=0) and pin B is driven (`casc_b_oe`=1). With `shift_right`=0 the roles are reversed. A driven pin stays low except during the end-of-line pulse.
- R3: A rising level on the input cascade pin, seen at a clock edge while idle, starts a capture. The data on the next 64 rising edges is stored, and `busy` is 1 from the start edge until the 64th data edge.
- R4: After the 64th data edge, capture halts. Later clocks with no new start pulse leave the store unchanged.
- R5: In the cycle after the 64th data edge, `line_done` and the driven cascade pin are both 1 for exactly one cycle.
- R6: A start pulse wider than one clock, or a new rising edge during a capture, starts no further capture.
- R7: With `shift_right`=1 at start, the byte on lane j (bits 8j+7..8j of `pix_data`) at data step k (0..63) goes to slot 6k+j.
- R8: With `shift_right`=0 at start, the byte on lane j at data step k goes to slot 6(63-k)+j.
- R9: `inv_lo` complements the bytes of lanes 0..2 and `inv_hi` complements lanes 3..5. Both controls are sampled with the data of the same step.
- R10: `rd_byte` shows the stored byte of slot `rd_idx` (0..383) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_right | input | 1 | Fill direction and cascade pin roles |
| casc_a_in | input | 1 | Cascade pin A, input value |
| casc_a_out | output | 1 | Cascade pin A, driven value |
| casc_a_oe | output | 1 | Cascade pin A, output enable |
| casc_b_in | input | 1 | Cascade pin B, input value |
| casc_b_out | output | 1 | Cascade pin B, driven value |
| casc_b_oe | output | 1 | Cascade pin B, output enable |
| pix_data | input | 48 | Six byte lanes, lane 0 in bits 7..0 |
| inv_lo | input | 1 | Complement lanes 0..2 |
| inv_hi | input | 1 | Complement lanes 3..5 |
| busy | output | 1 | Capture in progress |
| line_done | output | 1 | One-cycle strobe after the last data step |
| rd_idx | input | 9 | Store slot to read |
| rd_byte | output | 8 | Stored byte at `rd_idx` |

## Verification
The hardest case to reach is a second rising edge on the input pin in the middle of a capture, or a start level that stays high until after the line finishes. Either one could wrongly start a new capture and overwrite the store. The stimulus covers both: it pulls the pin low and raises it again at step 20 of a running line, and in another run it holds the pin high for a hundred cycles. After each, it reads back every slot and checks that the store still holds the expected contents and that `busy` stays low. Junk data is also clocked in after a finished line, and then the whole store is read back again.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
   // Fill direction as seen at the start of a capture
   typedef enum logic {
      FILL_LEFT  = 1'b0,
      FILL_RIGHT = 1'b1
   } fill_dir_e;

   // Lane-to-inversion-group split: lower half uses the low control
   function automatic logic lane_in_hi_group(input int lane, input int lanes);
      return (lane >= (lanes / 2));
   endfunction
endpackage

// File: rtl/lcap_cascade_io.sv
module lcap_cascade_io (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_right,
   input  logic a_in,
   input  logic b_in,
   input  logic busy,
   input  logic done_pulse,
   output logic start_ev,
   output logic a_out,
   output logic a_oe,
   output logic b_out,
   output logic b_oe
);
   logic start_lvl;
   logic start_prev;

   // Input pin chosen by direction
   assign start_lvl = shift_right ? a_in : b_in;

   always_ff @(posedge clk) begin
      if (!rst_n) start_prev <= 1'b0;
      else        start_prev <= start_lvl;
   end

   // Only a rising level while idle starts a line
   assign start_ev = start_lvl & ~start_prev & ~busy;

   // The pin that is not the input drives the end-of-line pulse
   assign a_oe  = ~shift_right;
   assign b_oe  =  shift_right;
   assign a_out = a_oe & done_pulse;
   assign b_out = b_oe & done_pulse;

   // R2: exactly one pin drives at a time
   p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({a_oe, b_oe}) == 1);

   // R6: a level held high produces no second start
   p_no_restart_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !start_ev);
endmodule

// File: rtl/lcap_seq.sv
module lcap_seq #(
   parameter int STEPS = 64,
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ev,
   input  logic             shift_right,
   output logic             busy,
   output logic             done_pulse,
   output logic             wr_en,
   output logic [CNT_W-1:0] grp
);
   import lcap_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0] step_q;
   fill_dir_e        dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         step_q     <= '0;
         done_pulse <= 1'b0;
         dir_q      <= FILL_RIGHT;
      end else begin
         done_pulse <= 1'b0;
         if (busy) begin
            if (step_q == LAST) begin
               busy       <= 1'b0;
               step_q     <= '0;
               done_pulse <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end else if (start_ev) begin
            busy   <= 1'b1;
            step_q <= '0;
            dir_q  <= fill_dir_e'(shift_right);
         end
      end
   end

   assign wr_en = busy;

   // Group position in the store depends on the direction taken at start
   generate
      if (STEPS > 1) begin : g_multi
         assign grp = (dir_q == FILL_RIGHT) ? step_q : (LAST - step_q);
      end else begin : g_single
         assign grp = '0;
      end
   endgenerate

   // R3: a start makes the block busy from step zero
   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (busy && step_q == '0));

   // R3: capture continues until the last step
   p_run_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step_q != LAST) |=> busy);

   // R4: the last step ends the capture and raises the strobe
   p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step_q == LAST) |=> (!busy && done_pulse));

   // R4: idle means the counter is parked
   p_idle_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (step_q == '0));

   // R5: the strobe lasts a single cycle
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
endmodule

// File: rtl/lcap_line_buf.sv
module lcap_line_buf #(
   parameter int LANES  = 6,
   parameter int BYTE_W = 8,
   parameter int STEPS  = 64,
   parameter bit INV_EN = 1'b1,
   localparam int SLOTS  = LANES * STEPS,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [CNT_W-1:0]        grp,
   input  logic [LANES*BYTE_W-1:0] pix,
   input  logic                    inv_lo,
   input  logic                    inv_hi,
   input  logic [SLOT_W-1:0]       rd_idx,
   output logic [BYTE_W-1:0]       rd_byte
);
   import lcap_pkg::*;

   logic [BYTE_W-1:0] store   [SLOTS];
   logic [BYTE_W-1:0] lane_wr [LANES];
   logic [SLOT_W-1:0] base;

   // Per-lane conditioning: inversion variant chosen at elaboration
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      if (INV_EN) begin : g_inv
         logic inv_sel;
         assign inv_sel    = lane_in_hi_group(j, LANES) ? inv_hi : inv_lo;
         assign lane_wr[j] = pix[j*BYTE_W +: BYTE_W] ^ {BYTE_W{inv_sel}};
      end else begin : g_plain
         assign lane_wr[j] = pix[j*BYTE_W +: BYTE_W];
      end
   end

   assign base = SLOT_W'(grp) * SLOT_W'(LANES);

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int j = 0; j < LANES; j++) begin
            store[base + SLOT_W'(j)] <= lane_wr[j];
         end
      end
   end

   assign rd_byte = (int'(rd_idx) < SLOTS) ? store[rd_idx] : '0;

   // R4: with no write, a steady read address sees a steady byte
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!$stable(rd_idx) || $stable(rd_byte)));
endmodule

// File: rtl/lcap_top.sv
module lcap_top #(
   parameter int LANES  = 6,
   parameter int BYTE_W = 8,
   parameter int STEPS  = 64,
   parameter bit INV_EN = 1'b1,
   localparam int SLOTS  = LANES * STEPS,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    shift_right,
   input  logic                    casc_a_in,
   output logic                    casc_a_out,
   output logic                    casc_a_oe,
   input  logic                    casc_b_in,
   output logic                    casc_b_out,
   output logic                    casc_b_oe,
   input  logic [LANES*BYTE_W-1:0] pix_data,
   input  logic                    inv_lo,
   input  logic                    inv_hi,
   output logic                    busy,
   output logic                    line_done,
   input  logic [SLOT_W-1:0]       rd_idx,
   output logic [BYTE_W-1:0]       rd_byte
);
   // Elaboration checks on the parameter set
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("lcap_top: LANES must be even and at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("lcap_top: BYTE_W must be positive");
   end
   if (STEPS < 2) begin : g_bad_steps
      $error("lcap_top: STEPS must be at least 2");
   end

   logic             start_ev;
   logic             wr_en;
   logic [CNT_W-1:0] grp;

   lcap_cascade_io u_io (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_right(shift_right),
      .a_in       (casc_a_in),
      .b_in       (casc_b_in),
      .busy       (busy),
      .done_pulse (line_done),
      .start_ev   (start_ev),
      .a_out      (casc_a_out),
      .a_oe       (casc_a_oe),
      .b_out      (casc_b_out),
      .b_oe       (casc_b_oe)
   );

   lcap_seq #(.STEPS(STEPS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ev   (start_ev),
      .shift_right(shift_right),
      .busy       (busy),
      .done_pulse (line_done),
      .wr_en      (wr_en),
      .grp        (grp)
   );

   lcap_line_buf #(
      .LANES (LANES),
      .BYTE_W(BYTE_W),
      .STEPS (STEPS),
      .INV_EN(INV_EN)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .grp    (grp),
      .pix    (pix_data),
      .inv_lo (inv_lo),
      .inv_hi (inv_hi),
      .rd_idx (rd_idx),
      .rd_byte(rd_byte)
   );

   // R5: the end pulse appears on the driven pin together with the strobe
   p_pulse_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> (casc_a_out || casc_b_out));

   // R6: no start is accepted while a line is being captured
   p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start_ev);
endmodule

// File: tb/lcap_top_tb_top.sv
module lcap_top_tb_top;
   localparam int LANES  = 6;
   localparam int BYTE_W = 8;
   localparam int STEPS  = 64;
   localparam int SLOTS  = LANES * STEPS;
   localparam int SLOT_W = $clog2(SLOTS);

   logic clk = 1'b0;
   logic rst_n;
   logic shift_right;
   logic casc_a_in, casc_b_in;
   logic casc_a_out, casc_a_oe, casc_b_out, casc_b_oe;
   logic [LANES*BYTE_W-1:0] pix_data;
   logic inv_lo, inv_hi;
   logic busy, line_done;
   logic [SLOT_W-1:0] rd_idx;
   logic [BYTE_W-1:0] rd_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit rd_req = 1'b0;
   string cur_tag = "R7";
   logic [BYTE_W-1:0] exp_q [$];
   logic [BYTE_W-1:0] exp_arr [SLOTS];

   always #2 clk = ~clk;

   lcap_top dut_i (
      .clk(clk), .rst_n(rst_n), .shift_right(shift_right),
      .casc_a_in(casc_a_in), .casc_a_out(casc_a_out), .casc_a_oe(casc_a_oe),
      .casc_b_in(casc_b_in), .casc_b_out(casc_b_out), .casc_b_oe(casc_b_oe),
      .pix_data(pix_data), .inv_lo(inv_lo), .inv_hi(inv_hi),
      .busy(busy), .line_done(line_done), .rd_idx(rd_idx), .rd_byte(rd_byte)
   );

   task automatic check(input string tag, input int got, input int expv);
      n_chk++;
      if (got != expv) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, expv);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int k, input int j);
      return 8'((seed * 37 + k * 7 + j * 29) & 255);
   endfunction

   // Scoreboard driver: fill expected store then push it slot by slot
   task automatic push_expect();
      for (int s = 0; s < SLOTS; s++) exp_q.push_back(exp_arr[s]);
   endtask

   task automatic wait_monitor();
      while (exp_q.size() > 0 || rd_req) @(negedge clk);
   endtask

   task automatic set_start(input bit dir, input bit v);
      if (dir) casc_a_in = v;
      else     casc_b_in = v;
   endtask

   task automatic run_line(input bit dir, input int seed, input bit il, input bit ih,
                           input int width, input bit retrig, input string tag);
      bit busy_bad = 1'b0;
      bit done_early = 1'b0;
      for (int k = 0; k < STEPS; k++) begin
         for (int j = 0; j < LANES; j++) begin
            int slot;
            logic [7:0] v;
            slot = dir ? (LANES * k + j) : (LANES * (STEPS - 1 - k) + j);
            v = pat(seed, k, j);
            if ((j < LANES / 2) ? il : ih) v = ~v;
            exp_arr[slot] = v;
         end
      end
      cur_tag = tag;
      push_expect();
      @(negedge clk);
      shift_right = dir;
      set_start(dir, 1'b1);
      for (int k = 0; k < STEPS; k++) begin
         @(negedge clk);
         if (busy !== 1'b1) busy_bad = 1'b1;
         if (line_done !== 1'b0) done_early = 1'b1;
         for (int j = 0; j < LANES; j++) pix_data[j*BYTE_W +: BYTE_W] = pat(seed, k, j);
         inv_lo = il;
         inv_hi = ih;
         set_start(dir, (k + 1 < width) ? 1'b1 : 1'b0);
         if (retrig && k == 20) set_start(dir, 1'b1);
      end
      @(negedge clk);
      check("R3 busy through 64 steps", int'(busy_bad), 0);
      check("R5 no early done", int'(done_early), 0);
      check("R5 line_done pulse", int'(line_done), 1);
      check("R4 halted", int'(busy), 0);
      check("R5 cascade out", int'(dir ? casc_b_out : casc_a_out), 1);
      check("R2 input pin quiet", int'(dir ? casc_a_out : casc_b_out), 0);
      pix_data = '1;
      if (width <= STEPS + 1) set_start(dir, 1'b0);
      @(negedge clk);
      check("R5 pulse ends", int'(line_done), 0);
      check("R5 cascade ends", int'(dir ? casc_b_out : casc_a_out), 0);
      wait_monitor();
   endtask

   // Scoreboard monitor: on each line end (or request) read the store
   initial begin
      rd_idx = '0;
      forever begin
         @(negedge clk);
         if (line_done || rd_req) begin
            for (int s = 0; s < SLOTS; s++) begin
               logic [7:0] e;
               rd_idx = SLOT_W'(s);
               #0.5;
               e = exp_q.pop_front();
               check({cur_tag, " R10 slot"}, int'(rd_byte), int'(e));
            end
            rd_req = 1'b0;
         end
      end
   end

   initial begin
      #600000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      shift_right = 1'b1;
      casc_a_in = 1'b0;
      casc_b_in = 1'b0;
      pix_data = '0;
      inv_lo = 1'b0;
      inv_hi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 line_done", int'(line_done), 0);
      check("R1 pin A out", int'(casc_a_out), 0);
      check("R1 pin B out", int'(casc_b_out), 0);
      check("R2 right A oe", int'(casc_a_oe), 0);
      check("R2 right B oe", int'(casc_b_oe), 1);

      // R7 right fill, single-clock pulse
      run_line(1'b1, 3, 1'b0, 1'b0, 1, 1'b0, "R7");

      // R4 junk clocks after the line, then read back unchanged store
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         pix_data = {8{c[5:0]}};
         inv_lo = c[0];
      end
      check("R4 stays idle", int'(busy), 0);
      cur_tag = "R4";
      push_expect();
      rd_req = 1'b1;
      wait_monitor();

      // R8 left fill with low-half inversion, 3-clock pulse
      shift_right = 1'b0;
      @(negedge clk);
      check("R2 left A oe", int'(casc_a_oe), 1);
      check("R2 left B oe", int'(casc_b_oe), 0);
      run_line(1'b0, 11, 1'b1, 1'b0, 3, 1'b0, "R8 R9");

      // R9 both halves inverted, right fill, retrigger mid-line (R6)
      run_line(1'b1, 25, 1'b1, 1'b1, 2, 1'b1, "R9 R6");

      // R6 pulse held far past the line end: only one capture
      run_line(1'b1, 40, 1'b0, 1'b1, 100, 1'b0, "R6");
      begin
         bit rebusy = 1'b0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (busy !== 1'b0) rebusy = 1'b1;
         end
         check("R6 held pulse no restart", int'(rebusy), 0);
         casc_a_in = 1'b0;
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule